// File: doc/BRIEF.md
# Write-Once Snooping Coherence Controller

This block keeps one private write-back cache coherent with its peers on a shared, snooped bus, using a four-state invalidation protocol. Each line is held as Invalid, Valid, Reserved or Dirty. The tags and states live in a small direct-mapped store. Data arrays are outside the block. The CPU side presents one load or store at a time and holds it until `cpu_done`. The block answers by issuing its own bus transactions: a line read, a line read that invalidates other copies, a single-word write-through, or a line write-back. At the same time it watches the transactions of other masters and may abort them.

The protocol handles the first store to a clean line differently from a plain write-back cache. The word goes through to memory, so every other cache sees it and drops its copy. The line is then Reserved, which means it is the only copy and still matches memory. A later store makes it Dirty without any bus traffic. When another master reads or claims a line this cache holds Dirty, its transaction is aborted. This cache then writes the line back, and the other master retries and gets the current data.

Bus transactions take one cycle. A master drives `bus_req` with its command and address. An external arbiter grants one master per cycle, and that transaction is fed to every other cache's snoop inputs in the same cycle. Any snooping cache may abort it combinationally. A granted transaction that is not aborted has completed at the next clock edge.

Top module: `wo_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `bus_req` and `cpu_done` are low until a CPU request arrives.
- R2: A CPU load that misses issues a line read (`bus_cmd` code 1) at the line-aligned address, with the offset bits zero. On completion the line is installed Valid, so a repeated load is then a hit.
- R3: A CPU load that hits a line in Valid, Reserved or Dirty raises `cpu_done` in the cycle of the request and issues no bus transaction.
- R4: A CPU store that hits a Valid line issues a word write-through (code 3) at the full word address. `cpu_done` rises in the cycle that write is granted and not aborted, and the line becomes Reserved.
- R5: A CPU store that hits a Reserved line moves it to Dirty with no bus transaction. A store that hits a Dirty line also completes with no bus transaction.
- R6: A CPU store that misses issues an invalidating line read (code 2) at the line-aligned address and installs the line directly in Dirty.
- R7: A snooped line read, invalidating read or word write (codes 1, 2, 3) that hits a Dirty line raises `snp_abort` in the same cycle. In the next cycle the block requests a line write-back (code 4) of that line. After the write-back the line is Valid for a plain read and Invalid for the other two codes.
- R8: A snooped line read that hits a Reserved line moves it to Valid without aborting. A snooped read that hits a Valid line leaves it unchanged.
- R9: A snooped invalidating read or word write that hits a Valid or Reserved line moves it to Invalid without aborting and without a write-back.
- R10: A CPU miss whose victim line is Dirty first writes the victim back (code 4) and only then reads the new line. A victim in Valid or Reserved is replaced without a write-back.
- R11: A pending snoop write-back takes precedence over any CPU action, so the aborted line is written back exactly once. A CPU access never completes in a cycle in which `snp_valid` is high.
- R12: `bus_cmd` only carries codes 1 to 4 while `bus_req` is high. Addresses are laid out as tag, then index, then word offset in the low `OFF_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | CPU request present; held until `cpu_done` |
| cpu_store | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_done | output | 1 | Request completes at this clock edge |
| bus_req | output | 1 | Bus transaction wanted this cycle |
| bus_cmd | output | 3 | 1 read, 2 invalidating read, 3 word write, 4 line write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_gnt | input | 1 | This master owns the bus this cycle |
| bus_abort | input | 1 | A peer aborted this cycle's transaction |
| snp_valid | input | 1 | A peer's granted transaction is on the bus |
| snp_cmd | input | 3 | Snooped command code |
| snp_addr | input | ADDR_W | Snooped address |
| snp_abort | output | 1 | Abort the snooped transaction |

## Verification
The assertions rely on the environment keeping certain promises. `snp_valid` is never high in a cycle in which this block holds `bus_gnt`. Snooped line commands carry a zero offset. A CPU request stays unchanged until `cpu_done`. The bench meets all of these by building the bus from two instances and a round-robin arbiter. Each cache's snoop inputs carry only the other cache's granted transaction, and that cache's `snp_abort` is returned as the master's `bus_abort`. CPU requests are driven by a task that holds them until completion, so every aborted access is retried by the hardware itself rather than by the stimulus.

// File: rtl/wo_coh_pkg.sv
package wo_coh_pkg;

   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_VAL = 2'd1,
      LS_RSV = 2'd2,
      LS_DRT = 2'd3
   } line_st_t;

   typedef enum logic [2:0] {
      BC_IDLE  = 3'd0,
      BC_READ  = 3'd1,
      BC_RDINV = 3'd2,
      BC_WWORD = 3'd3,
      BC_WLINE = 3'd4
   } bus_cmd_t;

   function automatic logic cmd_kills_copies(bus_cmd_t c);
      return (c == BC_RDINV) || (c == BC_WWORD);
   endfunction

endpackage

// File: rtl/wo_tag_store.sv
module wo_tag_store
   import wo_coh_pkg::*;
#(
   parameter int SETS  = 8,
   parameter int TAG_W = 3,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] w_idx,
   input  logic [TAG_W-1:0] w_tag,
   input  line_st_t         w_st,
   input  logic [IDX_W-1:0] a_idx,
   output logic [TAG_W-1:0] a_tag,
   output line_st_t         a_st,
   input  logic [IDX_W-1:0] b_idx,
   output logic [TAG_W-1:0] b_tag,
   output line_st_t         b_st,
   input  logic [IDX_W-1:0] c_idx,
   output logic [TAG_W-1:0] c_tag
);

   logic [SETS-1:0][TAG_W-1:0] tag_v;
   logic [SETS-1:0][1:0]       st_v;

   for (genvar g = 0; g < SETS; g++) begin : g_line
      logic [TAG_W-1:0] t_q;
      line_st_t         s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            t_q <= '0;
            s_q <= LS_INV;
         end else if (we && (w_idx == IDX_W'(g))) begin
            t_q <= w_tag;
            s_q <= w_st;
         end
      end
      assign tag_v[g] = t_q;
      assign st_v[g]  = s_q;
   end

   assign a_tag = tag_v[a_idx];
   assign a_st  = line_st_t'(st_v[a_idx]);
   assign b_tag = tag_v[b_idx];
   assign b_st  = line_st_t'(st_v[b_idx]);
   assign c_tag = tag_v[c_idx];

endmodule

// File: rtl/wo_snoop_unit.sv
module wo_snoop_unit
   import wo_coh_pkg::*;
#(
   parameter int TAG_W = 3
) (
   input  logic             snp_valid,
   input  bus_cmd_t         snp_cmd,
   input  logic [TAG_W-1:0] snp_tag,
   input  logic [TAG_W-1:0] lk_tag,
   input  line_st_t         lk_st,
   input  logic             pend_busy,
   output logic             abort,
   output logic             upd_en,
   output line_st_t         upd_st,
   output logic             pend_set,
   output logic             pend_to_val
);

   logic hit;
   logic is_rd;
   logic is_kill;

   assign hit     = snp_valid && (lk_st != LS_INV) && (lk_tag == snp_tag);
   assign is_rd   = (snp_cmd == BC_READ);
   assign is_kill = cmd_kills_copies(snp_cmd);

   always_comb begin
      abort       = 1'b0;
      upd_en      = 1'b0;
      upd_st      = lk_st;
      pend_set    = 1'b0;
      pend_to_val = is_rd;
      if (hit && (is_rd || is_kill)) begin
         if (lk_st == LS_DRT) begin
            abort    = 1'b1;
            pend_set = !pend_busy;
         end else if (is_kill) begin
            upd_en = 1'b1;
            upd_st = LS_INV;
         end else if (lk_st == LS_RSV) begin
            upd_en = 1'b1;
            upd_st = LS_VAL;
         end
      end
   end

endmodule

// File: rtl/wo_cpu_unit.sv
module wo_cpu_unit
   import wo_coh_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int OFF_W  = 2,
   parameter int IDX_W  = 3,
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
   input  logic              cpu_valid,
   input  logic              cpu_store,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [TAG_W-1:0]  lk_tag,
   input  line_st_t          lk_st,
   input  logic              hold,
   input  logic              snp_busy,
   input  logic              bus_gnt,
   input  logic              bus_abort,
   output logic              req,
   output bus_cmd_t          cmd,
   output logic [ADDR_W-1:0] addr,
   output logic              done,
   output logic              upd_en,
   output logic [TAG_W-1:0]  upd_tag,
   output line_st_t          upd_st
);

   logic [TAG_W-1:0] my_tag;
   logic [IDX_W-1:0] my_idx;
   logic             hit;
   logic             won;

   assign my_tag = cpu_addr[ADDR_W-1 -: TAG_W];
   assign my_idx = cpu_addr[OFF_W +: IDX_W];
   assign hit    = (lk_st != LS_INV) && (lk_tag == my_tag);
   assign won    = bus_gnt && !bus_abort;

   always_comb begin
      req     = 1'b0;
      cmd     = BC_IDLE;
      addr    = '0;
      done    = 1'b0;
      upd_en  = 1'b0;
      upd_tag = my_tag;
      upd_st  = lk_st;
      if (cpu_valid && !hold) begin
         if (hit) begin
            if (!cpu_store) begin
               done = !snp_busy;
            end else begin
               unique case (lk_st)
                  LS_VAL: begin
                     req  = 1'b1;
                     cmd  = BC_WWORD;
                     addr = cpu_addr;
                     if (won) begin
                        done   = 1'b1;
                        upd_en = 1'b1;
                        upd_st = LS_RSV;
                     end
                  end
                  LS_RSV: begin
                     done   = !snp_busy;
                     upd_en = !snp_busy;
                     upd_st = LS_DRT;
                  end
                  default: done = !snp_busy;
               endcase
            end
         end else if (lk_st == LS_DRT) begin
            req     = 1'b1;
            cmd     = BC_WLINE;
            addr    = {lk_tag, my_idx, {OFF_W{1'b0}}};
            upd_tag = lk_tag;
            if (won) begin
               upd_en = 1'b1;
               upd_st = LS_INV;
            end
         end else begin
            req  = 1'b1;
            cmd  = cpu_store ? BC_RDINV : BC_READ;
            addr = {my_tag, my_idx, {OFF_W{1'b0}}};
            if (won) begin
               upd_en = 1'b1;
               upd_st = cpu_store ? LS_DRT : LS_VAL;
            end
         end
      end
   end

endmodule

// File: rtl/wo_coh_ctrl.sv
module wo_coh_ctrl
   import wo_coh_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 4,
   parameter int SETS   = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_store,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_done,
   output logic              bus_req,
   output logic [2:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_gnt,
   input  logic              bus_abort,
   input  logic              snp_valid,
   input  logic [2:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_abort
);

   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

   if (OFF_W < 1) begin : g_bad_off
      initial $error("wo_coh_ctrl: OFF_W must be at least 1");
   end
   if ((SETS < 2) || ((1 << IDX_W) != SETS)) begin : g_bad_sets
      initial $error("wo_coh_ctrl: SETS must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      initial $error("wo_coh_ctrl: ADDR_W too small for SETS and OFF_W");
   end

   logic [IDX_W-1:0] cpu_idx;
   logic [IDX_W-1:0] sn_idx;
   logic [TAG_W-1:0] sn_tag;
   assign cpu_idx = cpu_addr[OFF_W +: IDX_W];
   assign sn_idx  = snp_addr[OFF_W +: IDX_W];
   assign sn_tag  = snp_addr[ADDR_W-1 -: TAG_W];

   logic             pend_q;
   logic [IDX_W-1:0] pend_idx_q;
   logic             pend_val_q;
   logic             pend_fin;

   logic             ts_we;
   logic [IDX_W-1:0] ts_idx;
   logic [TAG_W-1:0] ts_tag;
   line_st_t         ts_st;
   logic [TAG_W-1:0] cu_lk_tag, sn_lk_tag, pend_tag;
   line_st_t         cu_lk_st, sn_lk_st;

   wo_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ts_we),
      .w_idx (ts_idx),
      .w_tag (ts_tag),
      .w_st  (ts_st),
      .a_idx (cpu_idx),
      .a_tag (cu_lk_tag),
      .a_st  (cu_lk_st),
      .b_idx (sn_idx),
      .b_tag (sn_lk_tag),
      .b_st  (sn_lk_st),
      .c_idx (pend_idx_q),
      .c_tag (pend_tag)
   );

   logic     sn_upd, sn_pend_set, sn_pend_val;
   line_st_t sn_upd_st;

   wo_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
      .snp_valid   (snp_valid),
      .snp_cmd     (bus_cmd_t'(snp_cmd)),
      .snp_tag     (sn_tag),
      .lk_tag      (sn_lk_tag),
      .lk_st       (sn_lk_st),
      .pend_busy   (pend_q),
      .abort       (snp_abort),
      .upd_en      (sn_upd),
      .upd_st      (sn_upd_st),
      .pend_set    (sn_pend_set),
      .pend_to_val (sn_pend_val)
   );

   logic              cu_req, cu_upd;
   bus_cmd_t          cu_cmd;
   logic [ADDR_W-1:0] cu_addr;
   logic [TAG_W-1:0]  cu_upd_tag;
   line_st_t          cu_upd_st;

   wo_cpu_unit #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_cpu (
      .cpu_valid (cpu_valid),
      .cpu_store (cpu_store),
      .cpu_addr  (cpu_addr),
      .lk_tag    (cu_lk_tag),
      .lk_st     (cu_lk_st),
      .hold      (pend_q),
      .snp_busy  (snp_valid),
      .bus_gnt   (bus_gnt),
      .bus_abort (bus_abort),
      .req       (cu_req),
      .cmd       (cu_cmd),
      .addr      (cu_addr),
      .done      (cpu_done),
      .upd_en    (cu_upd),
      .upd_tag   (cu_upd_tag),
      .upd_st    (cu_upd_st)
   );

   assign pend_fin = pend_q && bus_gnt && !bus_abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         pend_idx_q <= '0;
         pend_val_q <= 1'b0;
      end else if (pend_fin) begin
         pend_q <= 1'b0;
      end else if (sn_pend_set) begin
         pend_q     <= 1'b1;
         pend_idx_q <= sn_idx;
         pend_val_q <= sn_pend_val;
      end
   end

   always_comb begin
      bus_req  = pend_q || cu_req;
      bus_cmd  = pend_q ? BC_WLINE : cu_cmd;
      bus_addr = pend_q ? {pend_tag, pend_idx_q, {OFF_W{1'b0}}} : cu_addr;
   end

   always_comb begin
      ts_we  = 1'b0;
      ts_idx = cpu_idx;
      ts_tag = cu_upd_tag;
      ts_st  = cu_upd_st;
      if (sn_upd) begin
         ts_we  = 1'b1;
         ts_idx = sn_idx;
         ts_tag = sn_lk_tag;
         ts_st  = sn_upd_st;
      end else if (pend_fin) begin
         ts_we  = 1'b1;
         ts_idx = pend_idx_q;
         ts_tag = pend_tag;
         ts_st  = pend_val_q ? LS_VAL : LS_INV;
      end else if (cu_upd) begin
         ts_we = 1'b1;
      end
   end

endmodule

// File: rtl/wo_coh_chk.sv
module wo_coh_chk #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_done,
   input logic              bus_req,
   input logic [2:0]        bus_cmd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_gnt,
   input logic              bus_abort,
   input logic              snp_valid,
   input logic [2:0]        snp_cmd,
   input logic [ADDR_W-1:0] snp_addr,
   input logic              snp_abort
);

   // R7: an abort only answers a transaction seen on the snoop inputs
   a_r7_abort_on_snoop: assert property (@(posedge clk) disable iff (!rst_n)
      snp_abort |-> snp_valid);

   // R7 / R11: after an abort the write-back is requested in the next cycle
   a_r7_abort_then_wb: assert property (@(posedge clk) disable iff (!rst_n)
      snp_abort |=> (bus_req && bus_cmd == 3'd4));

   // R11: the CPU never completes while a peer transaction is snooped
   a_r11_snoop_blocks_cpu: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> !cpu_done);

   // R4: a completed write-through finishes the CPU store in that cycle
   a_r4_wt_completes: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt && !bus_abort && bus_cmd == 3'd3) |-> cpu_done);

   // R2 / R6 / R10: line commands carry a zero offset
   a_r2_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_cmd != 3'd3) |-> (bus_addr[OFF_W-1:0] == '0));

   // R12: only legal command codes while requesting
   a_r12_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_cmd != 3'd0 && bus_cmd < 3'd5));

   // R12: environment side, snooped line commands carry a zero offset
   a_r12_snoop_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_cmd != 3'd3) |-> (snp_addr[OFF_W-1:0] == '0));

endmodule

bind wo_coh_ctrl wo_coh_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/tb_wo_coh_ctrl.sv
module tb_wo_coh_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int OW = 2;
   localparam int NS = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic          cv [2];
   logic          cs [2];
   logic [AW-1:0] ca [2];
   logic          dn0, dn1, req0, req1, gnt0, gnt1, ab0, ab1;
   logic [2:0]    cmd0, cmd1;
   logic [AW-1:0] ba0, ba1;
   logic          last_q;

   int n_tests = 0;
   int n_fail  = 0;
   int ok_cnt [2][8];
   int ab_cnt [2];
   logic [AW-1:0] la [2][8];

   assign gnt0 = req0 && (!req1 || last_q);
   assign gnt1 = req1 && !gnt0;

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else if (gnt0) last_q <= 1'b0;
      else if (gnt1) last_q <= 1'b1;
   end

   wo_coh_ctrl #(.ADDR_W(AW), .OFF_W(OW), .SETS(NS)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cv[0]), .cpu_store(cs[0]), .cpu_addr(ca[0]), .cpu_done(dn0),
      .bus_req(req0), .bus_cmd(cmd0), .bus_addr(ba0),
      .bus_gnt(gnt0), .bus_abort(ab1),
      .snp_valid(gnt1), .snp_cmd(cmd1), .snp_addr(ba1), .snp_abort(ab0));

   wo_coh_ctrl #(.ADDR_W(AW), .OFF_W(OW), .SETS(NS)) dut_peer (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cv[1]), .cpu_store(cs[1]), .cpu_addr(ca[1]), .cpu_done(dn1),
      .bus_req(req1), .bus_cmd(cmd1), .bus_addr(ba1),
      .bus_gnt(gnt1), .bus_abort(ab0),
      .snp_valid(gnt0), .snp_cmd(cmd0), .snp_addr(ba0), .snp_abort(ab1));

   always @(negedge clk) begin
      if (rst_n) begin
         if (gnt0) begin
            if (ab1) ab_cnt[0]++;
            else begin ok_cnt[0][cmd0]++; la[0][cmd0] = ba0; end
         end
         if (gnt1) begin
            if (ab0) ab_cnt[1]++;
            else begin ok_cnt[1][cmd1]++; la[1][cmd1] = ba1; end
         end
      end
   end

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic clr();
      for (int c = 0; c < 2; c++) begin
         ab_cnt[c] = 0;
         for (int k = 0; k < 8; k++) ok_cnt[c][k] = 0;
      end
   endtask

   // expected completed transactions: reads, invalidating reads, word writes, write-backs
   task automatic bus_exp(input string tag, input int c, input int rd, input int rx,
                          input int ww, input int wl);
      chk({tag, " read count"},   ok_cnt[c][1], rd);
      chk({tag, " rdinv count"},  ok_cnt[c][2], rx);
      chk({tag, " wword count"},  ok_cnt[c][3], ww);
      chk({tag, " wline count"},  ok_cnt[c][4], wl);
   endtask

   task automatic do_op(input int c, input logic st, input logic [AW-1:0] a, output int cyc);
      logic d;
      cyc = 0;
      @(posedge clk); #1;
      cv[c] = 1'b1; cs[c] = st; ca[c] = a;
      forever begin
         @(negedge clk);
         cyc++;
         d = (c == 0) ? dn0 : dn1;
         if (d || cyc > 500) break;
      end
      if (cyc > 500) begin
         n_fail++;
         $display("FAIL op hang: cache %0d addr %0h actual 0 expected done", c, a);
      end
      @(posedge clk); #1;
      cv[c] = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
   end

   initial begin
      int cy;
      for (int c = 0; c < 2; c++) begin cv[c] = 1'b0; cs[c] = 1'b0; ca[c] = '0; end
      clr();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 req0 after reset", int'(req0), 0);
      chk("R1 req1 after reset", int'(req1), 0);
      chk("R1 done after reset", int'(dn0 | dn1), 0);

      // R2: load miss from the reset state
      clr(); do_op(0, 0, 8'h12, cy);
      bus_exp("R2 load miss", 0, 1, 0, 0, 0);
      chk("R2 aligned read addr", int'(la[0][1]), 8'h10);
      // R3: load hit, done in first cycle
      clr(); do_op(0, 0, 8'h12, cy);
      chk("R3 load hit latency", cy, 1);
      bus_exp("R3 load hit", 0, 0, 0, 0, 0);
      // R4: store hit Valid -> write-through
      clr(); do_op(0, 1, 8'h11, cy);
      bus_exp("R4 store V", 0, 0, 0, 1, 0);
      chk("R4 word addr", int'(la[0][3]), 8'h11);
      // R5: Reserved -> Dirty and Dirty store silent
      clr(); do_op(0, 1, 8'h11, cy);
      bus_exp("R5 store R", 0, 0, 0, 0, 0);
      clr(); do_op(0, 1, 8'h11, cy);
      bus_exp("R5 store D", 0, 0, 0, 0, 0);
      // R7: peer read hits Dirty
      clr(); do_op(1, 0, 8'h10, cy);
      chk("R7 peer aborted", int'(ab_cnt[1] > 0), 1);
      bus_exp("R7 owner wb", 0, 0, 0, 0, 1);
      chk("R7 wb addr", int'(la[0][4]), 8'h10);
      bus_exp("R7 peer read", 1, 1, 0, 0, 0);
      // R7: owner left Valid -> next store writes through
      clr(); do_op(0, 1, 8'h11, cy);
      bus_exp("R7 owner now V", 0, 0, 0, 1, 0);
      // R9: peer invalidated by write-through -> misses
      clr(); do_op(1, 0, 8'h10, cy);
      bus_exp("R9 peer invalidated", 1, 1, 0, 0, 0);
      chk("R8 no abort on R", ab_cnt[1], 0);
      bus_exp("R8 no wb from R", 0, 0, 0, 0, 0);
      // R8: Reserved moved to Valid by snooped read
      clr(); do_op(0, 1, 8'h11, cy);
      bus_exp("R8 R became V", 0, 0, 0, 1, 0);
      // R6 / R9: store miss, other R copy invalidated silently
      clr(); do_op(1, 1, 8'h13, cy);
      bus_exp("R6 store miss", 1, 0, 1, 0, 0);
      chk("R6 rdinv addr", int'(la[1][2]), 8'h10);
      chk("R9 no abort", ab_cnt[1], 0);
      clr(); do_op(1, 1, 8'h13, cy);
      bus_exp("R6 installed Dirty", 1, 0, 0, 0, 0);
      // R7: owner reads back from the Dirty peer
      clr(); do_op(0, 0, 8'h10, cy);
      chk("R7 abort count", int'(ab_cnt[0] > 0), 1);
      bus_exp("R7 peer wb", 1, 0, 0, 0, 1);
      bus_exp("R2 refetch", 0, 1, 0, 0, 0);
      clr(); do_op(1, 1, 8'h11, cy);
      bus_exp("R7 D to V", 1, 0, 0, 1, 0);
      clr(); do_op(1, 1, 8'h11, cy);
      bus_exp("R5 second store", 1, 0, 0, 0, 0);
      // R7: invalidating read on Dirty -> wb then Invalid
      clr(); do_op(0, 1, 8'h11, cy);
      chk("R7 rdinv aborted", int'(ab_cnt[0] > 0), 1);
      bus_exp("R7 wb before kill", 1, 0, 0, 0, 1);
      bus_exp("R6 rdinv done", 0, 0, 1, 0, 0);
      clr(); do_op(1, 0, 8'h10, cy);
      bus_exp("R7 killed line misses", 1, 1, 0, 0, 0);
      bus_exp("R7 owner Dirty wb", 0, 0, 0, 0, 1);
      // R10: Dirty victim written back first
      clr(); do_op(0, 1, 8'h11, cy);
      clr(); do_op(0, 1, 8'h11, cy);
      clr(); do_op(0, 0, 8'h30, cy);
      bus_exp("R10 dirty victim", 0, 1, 0, 0, 1);
      chk("R10 victim addr", int'(la[0][4]), 8'h10);
      chk("R10 new line addr", int'(la[0][1]), 8'h30);
      clr(); do_op(0, 0, 8'h10, cy);
      bus_exp("R10 valid victim", 0, 1, 0, 0, 0);
      clr(); do_op(0, 1, 8'h11, cy);
      clr(); do_op(0, 0, 8'h30, cy);
      bus_exp("R10 reserved victim", 0, 1, 0, 0, 0);
      // R11: pending write-back precedes the owner's own miss
      clr(); do_op(0, 1, 8'h31, cy);
      clr(); do_op(0, 1, 8'h31, cy);
      clr();
      fork
         begin int c0; do_op(0, 0, 8'h50, c0); end
         begin int c1; do_op(1, 0, 8'h30, c1); end
      join
      bus_exp("R11 owner single wb", 0, 1, 0, 0, 1);
      bus_exp("R11 peer read", 1, 1, 0, 0, 0);
      chk("R11 peer aborted once", ab_cnt[1], 1);
      chk("R11 owner read addr", int'(la[0][1]), 8'h50);
      // sweep over all indices
      for (int i = 0; i < NS; i++) begin
         logic [AW-1:0] a;
         a = AW'((5 << 5) | (i << 2));
         clr(); do_op(0, 0, a, cy);
         bus_exp($sformatf("R2 sweep %0d", i), 0, 1, 0, 0, 0);
         clr(); do_op(0, 0, a + 8'd2, cy);
         chk($sformatf("R3 sweep %0d", i), cy, 1);
         clr(); do_op(1, 1, a + 8'd1, cy);
         bus_exp($sformatf("R6 sweep %0d", i), 1, 0, 1, 0, 0);
         chk($sformatf("R9 sweep no abort %0d", i), ab_cnt[1], 0);
         clr(); do_op(1, 1, a + 8'd1, cy);
         bus_exp($sformatf("R5 sweep %0d", i), 1, 0, 0, 0, 0);
         clr(); do_op(0, 0, a, cy);
         chk($sformatf("R7 sweep abort %0d", i), int'(ab_cnt[0] > 0), 1);
         bus_exp($sformatf("R7 sweep wb %0d", i), 1, 0, 0, 0, 1);
         chk($sformatf("R9 sweep refetch %0d", i), ok_cnt[0][1], 1);
      end
      summary();
      $finish;
   end

endmodule